// File: doc/BRIEF.md
# Power-On Strap Latch Sequencer

This block brings a clock generator out of power-up in a controlled order. While reset is held, and until configuration is settled, every clock output stays disabled. Three shared pins act only as inputs during that time. A slow tick, derived from the system clock, paces the sequence. After reset is released, the block waits a set number of ticks. It then reads the three strap levels on two consecutive ticks. If both readings agree, it latches them. In the same cycle it turns on the global output enable and the done flag, and the shared pins start driving clocks.

The three straps select tri-state test mode, spread-spectrum clocking, and a 48 MHz or 24 MHz output. Each strap is active low. A pin that nothing drives reads high, which models the internal pull-up. If two readings disagree, the wait starts again. A total tick limit forces a latch, so the sequence always ends within a known bound. With the default parameters and a 25 MHz system clock, one tick is 100 µs and the worst case is 26 ticks, about 2.6 ms. This stays below the 3 ms that the supply-to-clock start-up allows.

Top module: `strap_seq`

## Requirements
- R1: Until `done` is high, `out_en`, `clk_oe` and every bit of `pad_oe` are 0, including while `rst_n` is low.
- R2: With stable straps, `done` rises exactly (WAIT_TICKS+2)·TICK_DIV clock edges after `rst_n` is released. That is WAIT_TICKS ticks of waiting, one sampling tick and one confirming tick. State changes only on a tick.
- R3: If the strap value on the confirming tick differs from the value on the sampling tick, the block returns to the wait state with its wait count at zero. Sampling then restarts after another WAIT_TICKS ticks.
- R4: `done` and `out_en` rise in the same clock cycle, and `pad_oe` and `clk_oe` take their enabled value in that cycle too.
- R5: Strap bit 1 (spread) latched low gives `cfg_spread_on` = 1. Latched high gives 0.
- R6: Strap bit 2 (frequency select) latched low gives `cfg_sel_48` = 1, meaning 48 MHz. Latched high gives 0, meaning 24 MHz.
- R7: Strap bit 0 (test) latched low gives `cfg_test_mode` = 1. In that case `pad_oe` stays 000 and `clk_oe` stays 0 after `done`, while `out_en` still rises. Latched high gives normal mode, with `pad_oe` = 111 and `clk_oe` = 1 after `done`.
- R8: A strap whose `pin_drv` bit is 0 reads as high, whatever its `pin_val` bit is.
- R9: After `done`, the configuration outputs and the enables hold their values until the next reset. Later changes on `pin_val` and `pin_drv` have no effect.
- R10: On a confirming tick where the total tick count since reset has reached MAX_TICKS, the block latches the current strap value even when it disagrees with the sample. Before that count, a disagreement restarts the wait.
- R11: `done` is high no later than MAX_TICKS+WAIT_TICKS+2 ticks after reset release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset (power not yet stable) |
| pin_val | input | 3 | Level seen on each shared pin: bit 0 test, bit 1 spread, bit 2 frequency select |
| pin_drv | input | 3 | 1 when something external drives the pin, 0 when the pin floats (pull-up applies) |
| pad_oe | output | 3 | Output-driver enable for each shared pin (0 = pin is an input) |
| clk_oe | output | 1 | Driver enable for all clock outputs (low in test mode) |
| out_en | output | 1 | Global clock output enable |
| done | output | 1 | Configuration latched |
| cfg_test_mode | output | 1 | Tri-state test mode selected |
| cfg_spread_on | output | 1 | Spread-spectrum clocking enabled |
| cfg_sel_48 | output | 1 | 1 selects 48 MHz, 0 selects 24 MHz |

## Verification
The assertions assume that `pin_val` and `pin_drv` are asynchronous, that they can change at any time, and that they reach the state machine only through the two-stage synchronizer. The assertions also assume that ticks come only from the internal divider. The stimulus changes pin levels only on the falling clock edge. Where a sample must see a known value, the change is placed at least two cycles before the tick. For the mismatch and timeout cases, the change is placed halfway between ticks, so each tick sees a value that has already settled.

// File: rtl/strap_pkg.sv
package strap_pkg;
    localparam int unsigned NUM_STRAPS = 3;
    localparam int unsigned IDX_TEST   = 0;
    localparam int unsigned IDX_SPREAD = 1;
    localparam int unsigned IDX_SEL48  = 2;

    typedef enum logic [1:0] {
        ST_WAIT    = 2'd0,
        ST_SAMPLE  = 2'd1,
        ST_CONFIRM = 2'd2,
        ST_DONE    = 2'd3
    } seq_state_e;
endpackage

// File: rtl/strap_tick.sv
module strap_tick #(
    parameter int unsigned DIV = 2500
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);
    localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } tick_st_t;

    tick_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.cnt == LAST) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tick_o = (st_q.cnt == LAST);

    generate
        if (DIV > 1) begin : g_spacing
            AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
                tick_o |=> !tick_o); // R2
        end
    endgenerate
endmodule

// File: rtl/strap_sync.sv
module strap_sync #(
    parameter int unsigned N      = 3,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] pin_val,
    input  logic [N-1:0] pin_drv,
    output logic [N-1:0] strap_o
);
    logic [N-1:0] resolved;

    generate
        for (genvar i = 0; i < N; i++) begin : g_pull
            assign resolved[i] = pin_drv[i] ? pin_val[i] : 1'b1;
        end
    endgenerate

    typedef struct packed {
        logic [STAGES-1:0][N-1:0] stg;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.stg[0] = resolved;
        for (int k = 1; k < int'(STAGES); k++) begin
            st_d.stg[k] = st_q.stg[k-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign strap_o = st_q.stg[STAGES-1];
endmodule

// File: rtl/strap_fsm.sv
module strap_fsm
    import strap_pkg::*;
#(
    parameter int unsigned N          = 3,
    parameter int unsigned WAIT_TICKS = 4,
    parameter int unsigned MAX_TICKS  = 20
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick_i,
    input  logic [N-1:0] strap_i,
    output logic         done_o,
    output logic         oen_o,
    output logic [N-1:0] cfg_o
);
    localparam int unsigned WW = $clog2(WAIT_TICKS + 1);
    localparam int unsigned TW = $clog2(MAX_TICKS + 1);
    localparam logic [WW-1:0] WLAST = WW'(WAIT_TICKS - 1);
    localparam logic [TW-1:0] TMAX  = TW'(MAX_TICKS);
    localparam int unsigned BOUND = MAX_TICKS + WAIT_TICKS + 2;

    typedef struct packed {
        seq_state_e    state;
        logic [WW-1:0] wcnt;
        logic [TW-1:0] tcnt;
        logic [N-1:0]  first;
        logic [N-1:0]  cfg;
        logic          done;
        logic          oen;
    } fsm_st_t;

    fsm_st_t st_d, st_q;
    logic [TW-1:0] tinc;
    logic          timeout;

    always_comb begin
        tinc    = (st_q.tcnt == TMAX) ? st_q.tcnt : st_q.tcnt + TW'(1);
        timeout = (tinc == TMAX);
        st_d    = st_q;
        if (tick_i && st_q.state != ST_DONE) begin
            st_d.tcnt = tinc;
            case (st_q.state)
                ST_WAIT: begin
                    if (st_q.wcnt == WLAST) begin
                        st_d.wcnt  = '0;
                        st_d.state = ST_SAMPLE;
                    end else begin
                        st_d.wcnt = st_q.wcnt + WW'(1);
                    end
                end
                ST_SAMPLE: begin
                    st_d.first = strap_i;
                    st_d.state = ST_CONFIRM;
                end
                ST_CONFIRM: begin
                    if (strap_i == st_q.first || timeout) begin
                        st_d.cfg   = strap_i;
                        st_d.done  = 1'b1;
                        st_d.oen   = 1'b1;
                        st_d.state = ST_DONE;
                    end else begin
                        st_d.wcnt  = '0;
                        st_d.state = ST_WAIT;
                    end
                end
                default: st_d.state = ST_DONE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.state <= ST_WAIT;
            st_q.wcnt  <= '0;
            st_q.tcnt  <= '0;
            st_q.first <= '1;
            st_q.cfg   <= '1;
            st_q.done  <= 1'b0;
            st_q.oen   <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign done_o = st_q.done;
    assign oen_o  = st_q.oen;
    assign cfg_o  = st_q.cfg;

    int unsigned chk_ticks;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chk_ticks <= 0;
        end else if (tick_i && chk_ticks <= BOUND) begin
            chk_ticks <= chk_ticks + 1;
        end
    end

    AST_MOVE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_i |=> $stable(st_q.state)); // R2
    AST_RESTART_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && st_q.state == ST_CONFIRM && strap_i != st_q.first && !timeout)
            |=> (st_q.state == ST_WAIT && st_q.wcnt == '0)); // R3
    AST_ENABLE_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.oen) |-> $rose(st_q.done)); // R4
    AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.done |=> (st_q.done && $stable(st_q.cfg))); // R9
    AST_BOUNDED_START: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_ticks >= BOUND) |-> st_q.done); // R11
endmodule

// File: rtl/strap_seq.sv
module strap_seq
    import strap_pkg::*;
#(
    parameter int unsigned TICK_DIV   = 2500,
    parameter int unsigned WAIT_TICKS = 4,
    parameter int unsigned MAX_TICKS  = 20
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_STRAPS-1:0] pin_val,
    input  logic [NUM_STRAPS-1:0] pin_drv,
    output logic [NUM_STRAPS-1:0] pad_oe,
    output logic                  clk_oe,
    output logic                  out_en,
    output logic                  done,
    output logic                  cfg_test_mode,
    output logic                  cfg_spread_on,
    output logic                  cfg_sel_48
);
    logic                  tick;
    logic [NUM_STRAPS-1:0] strap_s;
    logic [NUM_STRAPS-1:0] cfg_raw;
    logic                  oen;
    logic                  drive_ok;

    strap_tick #(.DIV(TICK_DIV)) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_o (tick)
    );

    strap_sync #(.N(NUM_STRAPS), .STAGES(2)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin_val (pin_val),
        .pin_drv (pin_drv),
        .strap_o (strap_s)
    );

    strap_fsm #(
        .N          (NUM_STRAPS),
        .WAIT_TICKS (WAIT_TICKS),
        .MAX_TICKS  (MAX_TICKS)
    ) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_i  (tick),
        .strap_i (strap_s),
        .done_o  (done),
        .oen_o   (oen),
        .cfg_o   (cfg_raw)
    );

    // Straps are active low; the reset value of cfg_raw is all ones.
    assign cfg_test_mode = ~cfg_raw[IDX_TEST];
    assign cfg_spread_on = ~cfg_raw[IDX_SPREAD];
    assign cfg_sel_48    = ~cfg_raw[IDX_SEL48];

    assign drive_ok = oen & cfg_raw[IDX_TEST];
    assign out_en   = oen;
    assign clk_oe   = drive_ok;
    assign pad_oe   = {NUM_STRAPS{drive_ok}};

    AST_QUIET_BEFORE_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> (pad_oe == '0 && !clk_oe && !out_en)); // R1
endmodule

// File: tb/sim_strap_seq.sv
module sim_strap_seq;
    localparam int unsigned DIV  = 8;
    localparam int unsigned WT   = 4;
    localparam int unsigned MT   = 20;
    localparam int unsigned DONE_EDGE = (WT + 2) * DIV;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] pin_val = 3'b111;
    logic [2:0] pin_drv = 3'b111;
    logic [2:0] pad_oe;
    logic       clk_oe, out_en, done;
    logic       cfg_test_mode, cfg_spread_on, cfg_sel_48;

    int nvec = 0;
    int nbad = 0;

    always #4 clk = ~clk;

    strap_seq #(.TICK_DIV(DIV), .WAIT_TICKS(WT), .MAX_TICKS(MT)) u0 (
        .clk           (clk),
        .rst_n         (rst_n),
        .pin_val       (pin_val),
        .pin_drv       (pin_drv),
        .pad_oe        (pad_oe),
        .clk_oe        (clk_oe),
        .out_en        (out_en),
        .done          (done),
        .cfg_test_mode (cfg_test_mode),
        .cfg_spread_on (cfg_spread_on),
        .cfg_sel_48    (cfg_sel_48)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nvec++;
        if (act !== exp) begin
            nbad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic start(input logic [2:0] val, input logic [2:0] drv);
        @(negedge clk);
        rst_n   = 1'b0;
        pin_val = val;
        pin_drv = drv;
        step(3);
        chk("R1 reset enables", {out_en, done, clk_oe, pad_oe}, 32'h0);
        rst_n = 1'b1;
    endtask

    task automatic t_basic(input string tag, input logic [2:0] val, input logic [2:0] drv,
                           input logic tm, input logic sp, input logic s48);
        start(val, drv);
        step(DONE_EDGE - 1);
        chk({tag, " R1 R2 quiet before latch"}, {out_en, done, clk_oe, pad_oe}, 32'h0);
        step(1);
        chk({tag, " R2 R4 enable with done"}, {out_en, done}, 32'h3);
        chk({tag, " R7 drive enables"}, {clk_oe, pad_oe}, tm ? 32'h0 : 32'hF);
        chk({tag, " R5 R6 R7 R8 cfg"}, {cfg_test_mode, cfg_spread_on, cfg_sel_48}, {tm, sp, s48});
    endtask

    task automatic t_frozen;
        t_basic("R9 setup", 3'b111, 3'b111, 1'b0, 1'b0, 1'b0);
        pin_val = 3'b000;
        step(60);
        chk("R9 frozen cfg", {cfg_test_mode, cfg_spread_on, cfg_sel_48}, 32'h0);
        chk("R9 frozen enables", {out_en, done, clk_oe, pad_oe}, 32'h3F);
    endtask

    task automatic t_mismatch;
        start(3'b111, 3'b111);
        step(44);
        pin_val = 3'b101;
        step(DONE_EDGE - 44);
        chk("R3 no latch on mismatch", {done, out_en}, 32'h0);
        step(2 * DONE_EDGE - DONE_EDGE - 1);
        chk("R3 still waiting after restart", {done, out_en}, 32'h0);
        step(1);
        chk("R3 latch after restart", {done, out_en}, 32'h3);
        chk("R3 R5 new value latched", {cfg_test_mode, cfg_spread_on, cfg_sel_48}, 32'h2);
    endtask

    task automatic t_timeout;
        start(3'b111, 3'b111);
        for (int e = 1; e <= 191; e++) begin
            step(1);
            if (e % 8 == 4) pin_val[0] = ~pin_val[0];
            if (e == 144) chk("R10 no early latch", {32'(done)}, 32'h0);
        end
        chk("R10 not latched before limit", {32'(done)}, 32'h0);
        step(1);
        chk("R10 R11 latched by limit", {done, out_en}, 32'h3);
        chk("R10 latest value used", {32'(cfg_test_mode)}, 32'h0);
    endtask

    bit finished = 1'b0;

    initial begin
        #(200000 * 8);
        if (!finished) begin
            nvec++;
            nbad++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
            $finish;
        end
    end

    initial begin
        t_basic("normal", 3'b111, 3'b111, 1'b0, 1'b0, 1'b0);
        t_basic("R5 R6 straps low", 3'b001, 3'b111, 1'b0, 1'b1, 1'b1);
        t_basic("R7 test mode", 3'b110, 3'b111, 1'b1, 1'b0, 1'b0);
        t_basic("R8 floating", 3'b000, 3'b000, 1'b0, 1'b0, 1'b0);
        t_basic("R8 mixed", 3'b000, 3'b010, 1'b0, 1'b1, 1'b0);
        t_frozen;
        t_mismatch;
        t_timeout;
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end
endmodule